// File: doc/BRIEF.md
# Dual Signed Halfword Multiply-Accumulate Unit

This block executes a family of four packed-DSP operations on 32-bit words. Each operand is split into two signed halfwords. The block forms the low-by-low and high-by-high products and then either adds them or subtracts the second from the first. It can then add a full-width accumulator. A control bit can swap the two halves of the second multiplicand first, so the products become crossed.

The block takes the raw instruction word and extracts the fields it needs. These are the condition code, the destination index, the accumulator index (whose value also selects accumulation), the exchange bit and the add/subtract selector. Execution is gated by the condition code together with a pass/fail input from external flag logic. The result, the destination index and a write enable are registered and appear one clock after the instruction is presented. The unit never saturates the result. It raises `q_set` when a signed overflow occurs, and the status logic outside uses that pulse to set its sticky Q bit (bit 27 of the status word). It never clears that bit.

The halfword width is a parameter, HALF_W, default 16. The data width is twice that value. The instruction word stays 32 bits wide.

Top module: `dual_mac_unit`

## Requirements
- R1: On an executed instruction, `rd_idx` takes instruction bits 19:16 and `rd_we` pulses high for one cycle, in the clock after the instruction is presented.
- R2: When instruction bit 5 is 1, the two halves of `rm_val` are exchanged before multiplying. The product pairs are then low(rn)·high(rm) and high(rn)·low(rm).
- R3: The two products are signed HALF_W×HALF_W products, each kept at data width. Instruction bit 6 = 0 selects their sum and bit 6 = 1 selects first minus second, modulo 2^DATA_W.
- R4: If instruction bits 15:12 equal 15, no accumulator is added. For any other value, `acc_val` is added to the sum or difference, modulo 2^DATA_W.
- R5: In add mode (bit 6 = 0), `q_set` rises when the sum of the two products overflows as a signed value. Overflow means both addends share a sign and the result's sign differs from it.
- R6: When accumulating, `q_set` also rises when adding the accumulator to the sum or difference overflows as a signed value, in either mode.
- R7: In subtract mode the product difference alone never raises `q_set`. Without accumulation, a subtract instruction never raises it.
- R8: Condition code 0xE (bits 31:28) executes regardless of `cond_pass`. Any other code executes only when `cond_pass` is 1. A failed condition leaves `rd_we` and `q_set` low and `rd_value`/`rd_idx` unchanged.
- R9: Cycles without a valid instruction give `rd_we` = 0 and `q_set` = 0 and leave `rd_value` unchanged. After reset `rd_we`, `q_set`, `rd_idx` and `rd_value` are 0.
- R10: With both operands equal to 0x80008000 in add mode and no accumulation, the result is 0x80000000 and `q_set` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check result from external flag logic |
| rn_val | input | DATA_W | First multiplicand word |
| rm_val | input | DATA_W | Second multiplicand word |
| acc_val | input | DATA_W | Accumulator word |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | 4 | Destination register index |
| rd_value | output | DATA_W | Result word |
| q_set | output | 1 | Request to set the sticky overflow flag |

## Verification
The bench builds two copies of the unit. The first uses HALF_W = 16 and takes directed cases: the 0x8000 corner, accumulator overflow in both modes, exchange, condition gating and hold behaviour. The second uses HALF_W = 3, which gives 6-bit words. Its small word size allows every pair of multiplicands to be swept under all eight combinations of exchange, subtract and accumulate. That sweep covers every sign combination and every overflow boundary, and each result and flag is compared with an integer-range model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam logic [3:0] COND_ALWAYS = 4'hE;
  localparam logic [3:0] ACC_NONE    = 4'hF;

  typedef struct packed {
    logic [3:0] cond;
    logic [3:0] dst;
    logic [3:0] acc_reg;
    logic       exch;
    logic       subtract;
    logic       acc_en;
  } dmac_fields_t;

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic [31:0]  instr,
  output dmac_fields_t fields
);

  logic unused_bits;
  assign unused_bits = ^{instr[27:20], instr[11:7], instr[4:0]};

  always_comb begin
    fields.cond     = instr[31:28];
    fields.dst      = instr[19:16];
    fields.acc_reg  = instr[15:12];
    fields.exch     = instr[5];
    fields.subtract = instr[6];
    fields.acc_en   = (instr[15:12] != ACC_NONE);
  end

endmodule

// File: rtl/dmac_arith.sv
module dmac_arith #(
  parameter int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] acc_val,
  input  logic              exch,
  input  logic              subtract,
  input  logic              acc_en,
  output logic [DATA_W-1:0] result,
  output logic              q_flag,
  output logic              ovf_pair,
  output logic              ovf_acc
);

  function automatic logic [DATA_W-1:0] swap_halves(input logic [DATA_W-1:0] w);
    return {w[HALF_W-1:0], w[DATA_W-1:HALF_W]};
  endfunction

  function automatic logic [DATA_W-1:0] sext_half(input logic [HALF_W-1:0] h);
    return {{HALF_W{h[HALF_W-1]}}, h};
  endfunction

  function automatic logic [DATA_W-1:0] mul_half(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y);
    logic signed [DATA_W-1:0] xs, ys, p;
    xs = signed'(sext_half(x));
    ys = signed'(sext_half(y));
    p  = xs * ys;
    return p;
  endfunction

  function automatic logic add_overflows(input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] s;
    s = a + b;
    return (a[DATA_W-1] == b[DATA_W-1]) && (s[DATA_W-1] != a[DATA_W-1]);
  endfunction

  logic [DATA_W-1:0] rm_eff;
  logic [DATA_W-1:0] prod [2];
  logic [DATA_W-1:0] pair_sum, pair_diff, pair_res;

  assign rm_eff = exch ? swap_halves(rm_val) : rm_val;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign prod[g] = mul_half(rn_val[g*HALF_W +: HALF_W], rm_eff[g*HALF_W +: HALF_W]);
  end

  assign pair_sum  = prod[0] + prod[1];
  assign pair_diff = prod[0] - prod[1];
  assign pair_res  = subtract ? pair_diff : pair_sum;

  assign ovf_pair = !subtract && add_overflows(prod[0], prod[1]);
  assign ovf_acc  = acc_en && add_overflows(pair_res, acc_val);

  assign result = acc_en ? (pair_res + acc_val) : pair_res;
  assign q_flag = ovf_pair || ovf_acc;

endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
  import dmac_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  input  logic              cond_pass,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] acc_val,
  output logic              rd_we,
  output logic [3:0]        rd_idx,
  output logic [DATA_W-1:0] rd_value,
  output logic              q_set
);

  dmac_fields_t      f;
  logic              exec;
  logic [DATA_W-1:0] res;
  logic              q_raw, ovf_pair, ovf_acc;

  dmac_decode u_dec (
    .instr  (instr),
    .fields (f)
  );

  dmac_arith #(.HALF_W(HALF_W)) u_arith (
    .rn_val   (rn_val),
    .rm_val   (rm_val),
    .acc_val  (acc_val),
    .exch     (f.exch),
    .subtract (f.subtract),
    .acc_en   (f.acc_en),
    .result   (res),
    .q_flag   (q_raw),
    .ovf_pair (ovf_pair),
    .ovf_acc  (ovf_acc)
  );

  assign exec = instr_valid && ((f.cond == COND_ALWAYS) || cond_pass);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_we    <= 1'b0;
      q_set    <= 1'b0;
      rd_idx   <= '0;
      rd_value <= '0;
    end else begin
      rd_we <= exec;
      q_set <= exec && q_raw;
      if (exec) begin
        rd_idx   <= f.dst;
        rd_value <= res;
      end
    end
  end

  AST_FAIL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && f.cond != COND_ALWAYS && !cond_pass) |=> (!rd_we && !q_set)); // R8

  AST_Q_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    q_set |-> rd_we); // R8

  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!rd_we && !q_set)); // R9

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(rd_value)); // R9

  AST_SUB_DIFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && f.subtract && !f.acc_en) |=> !q_set); // R7

  AST_PAIR_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && ovf_pair) |=> q_set); // R5

  AST_ACC_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && ovf_acc) |=> q_set); // R6

endmodule

// File: tb/sim_dual_mac_unit.sv
`timescale 1ns/1ps
module sim_dual_mac_unit;

  localparam int SW = 3;
  localparam int SD = 2 * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic        v0 = 1'b0, cp0 = 1'b0;
  logic [31:0] in0 = '0;
  logic [31:0] rn0 = '0, rm0 = '0, ac0 = '0;
  logic        we0, q0;
  logic [3:0]  ix0;
  logic [31:0] rv0;

  logic          v1 = 1'b0, cp1 = 1'b0;
  logic [31:0]   in1 = '0;
  logic [SD-1:0] rn1 = '0, rm1 = '0, ac1 = '0;
  logic          we1, q1;
  logic [3:0]    ix1;
  logic [SD-1:0] rv1;

  dual_mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(v0), .instr(in0), .cond_pass(cp0),
    .rn_val(rn0), .rm_val(rm0), .acc_val(ac0),
    .rd_we(we0), .rd_idx(ix0), .rd_value(rv0), .q_set(q0)
  );

  dual_mac_unit #(.HALF_W(SW)) u_small (
    .clk(clk), .rst_n(rst_n), .instr_valid(v1), .instr(in1), .cond_pass(cp1),
    .rn_val(rn1), .rm_val(rm1), .acc_val(ac1),
    .rd_we(we1), .rd_idx(ix1), .rd_value(rv1), .q_set(q1)
  );

  function automatic logic [31:0] mk(input logic [3:0] cond, input logic [3:0] dst,
                                     input logic [3:0] accf, input bit sub, input bit exch);
    return {cond, 8'h70, dst, accf, 4'h2, 1'b0, sub, exch, 1'b1, 4'h1};
  endfunction

  function automatic longint sx(input longint v, input int w);
    longint m = v & ((longint'(1) << w) - 1);
    if (m >= (longint'(1) << (w - 1))) m = m - (longint'(1) << w);
    return m;
  endfunction

  function automatic void model(input int hw, input longint rn, input longint rm,
                                input longint acc, input bit exch, input bit sub,
                                input bit accen, output longint res, output bit q);
    int dw = 2 * hw;
    longint hm = (longint'(1) << hw) - 1;
    longint mask = (longint'(1) << dw) - 1;
    longint mx = (longint'(1) << (dw - 1)) - 1;
    longint mn = -(longint'(1) << (dw - 1));
    longint r2, p1, p2, base, t;
    q = 1'b0;
    r2 = exch ? (((rm & hm) << hw) | ((rm >> hw) & hm)) : rm;
    p1 = sx(rn, hw) * sx(r2, hw);
    p2 = sx(rn >> hw, hw) * sx(r2 >> hw, hw);
    if (!sub) begin
      t = p1 + p2;
      if (t > mx || t < mn) q = 1'b1;
    end else begin
      t = p1 - p2;
    end
    base = sx(t, dw);
    if (accen) begin
      t = base + sx(acc, dw);
      if (t > mx || t < mn) q = 1'b1;
      res = t & mask;
    end else begin
      res = base & mask;
    end
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op0(input logic [31:0] ins, input bit cp, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] c);
    v0 = 1'b1; in0 = ins; cp0 = cp; rn0 = a; rm0 = b; ac0 = c;
    @(negedge clk);
    v0 = 1'b0;
  endtask

  initial begin
    #900000;
    if (!finished) begin
      n_bad++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    longint er;
    bit eq;
    repeat (3) @(negedge clk);
    chk("R9 reset we", we0, 0);
    chk("R9 reset q", q0, 0);
    chk("R9 reset value", rv0, 0);
    chk("R9 reset idx", ix0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 corner: 0x8000 halves, add, no accumulate
    op0(mk(4'hE, 4'd3, 4'hF, 0, 0), 0, 32'h80008000, 32'h80008000, 32'h12345678);
    chk("R10 value", rv0, 32'h80000000);
    chk("R10 q", q0, 1);
    chk("R1 idx", ix0, 3);
    chk("R1 we", we0, 1);
    // R7: same operands, subtract, no accumulate
    op0(mk(4'hE, 4'd4, 4'hF, 1, 0), 0, 32'h80008000, 32'h80008000, 0);
    chk("R7 value", rv0, 0);
    chk("R7 q", q0, 0);
    // R4 accumulate and no-accumulate
    op0(mk(4'hE, 4'd9, 4'd2, 0, 0), 0, 32'h00010002, 32'h00030004, 32'd100);
    chk("R4 acc value", rv0, 111);
    chk("R1 idx 9", ix0, 9);
    op0(mk(4'hE, 4'd9, 4'hF, 0, 0), 0, 32'h00010002, 32'h00030004, 32'd100);
    chk("R4 noacc value", rv0, 11);
    // R2 exchange
    op0(mk(4'hE, 4'd1, 4'hF, 0, 1), 0, 32'h00010002, 32'h00030004, 0);
    chk("R2 exch value", rv0, 10);
    // R3 subtract: 2*4 - 1*3
    op0(mk(4'hE, 4'd1, 4'hF, 1, 0), 0, 32'h00010002, 32'h00030004, 0);
    chk("R3 diff value", rv0, 5);
    // R6 accumulator overflow, both modes
    op0(mk(4'hE, 4'd2, 4'd0, 0, 0), 0, 32'h00000001, 32'h00000001, 32'h7FFFFFFF);
    chk("R6 add value", rv0, 32'h80000000);
    chk("R6 add q", q0, 1);
    op0(mk(4'hE, 4'd2, 4'd0, 1, 0), 0, 32'h00000001, 32'h00000001, 32'h7FFFFFFF);
    chk("R6 sub q", q0, 1);
    // R8 condition gating
    op0(mk(4'h0, 4'd7, 4'hF, 0, 0), 0, 32'h80008000, 32'h80008000, 0);
    chk("R8 fail we", we0, 0);
    chk("R8 fail q", q0, 0);
    chk("R8 fail value held", rv0, 32'h80000000);
    chk("R8 fail idx held", ix0, 2);
    op0(mk(4'h0, 4'd7, 4'hF, 0, 0), 1, 32'h00010002, 32'h00030004, 0);
    chk("R8 pass we", we0, 1);
    chk("R8 pass value", rv0, 11);
    op0(mk(4'hE, 4'd6, 4'hF, 0, 0), 0, 32'h00020002, 32'h00020002, 0);
    chk("R8 always value", rv0, 8);
    // R9 idle cycle
    in0 = mk(4'hE, 4'd5, 4'hF, 0, 0); rn0 = 32'h7; rm0 = 32'h7;
    @(negedge clk);
    chk("R9 idle we", we0, 0);
    chk("R9 idle value", rv0, 8);

    // exhaustive small sweep: R2 R3 R4 R5 R6 R7
    for (int mode = 0; mode < 8; mode++) begin
      for (int a = 0; a < (1 << SD); a++) begin
        for (int b = 0; b < (1 << SD); b++) begin
          bit ex = mode[0];
          bit sb = mode[1];
          bit ae = mode[2];
          longint c = (a * 5 + b * 3 + mode * 7) & ((1 << SD) - 1);
          model(SW, a, b, c, ex, sb, ae, er, eq);
          v1 = 1'b1; cp1 = 1'b0;
          in1 = mk(4'hE, 4'(b), ae ? 4'd1 : 4'hF, sb, ex);
          rn1 = SD'(a); rm1 = SD'(b); ac1 = SD'(c);
          @(negedge clk);
          chk("R3_R4_R2 sweep value", rv1, er);
          chk("R5_R6_R7 sweep q", q1, eq);
          chk("R1 sweep idx", ix1, b & 15);
        end
      end
    end
    v1 = 1'b0;
    @(negedge clk);
    chk("R9 small idle we", we1, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule